// File: doc/BRIEF.md
# Stop-Mode Wake and Clock-Enable Controller

This block holds one control register of a small microcontroller together with the logic around it. It makes the single clock enable used by the system and timer logic, with a period of 1, 2, 16 or 32 input-clock cycles. While the device is stopped, it watches one chosen wake pin, or a NOR of a port group, for a programmed level. On a match it ends the stop state, gives a one-cycle wake pulse and then holds a reset request for a short or a long time. A sticky flag shows whether the device last started from power-on or from a stop wake.

Software writes the seven configuration bits through a plain address/data port at the register address. A read of that address returns only the status flag, in the top bit. Power-on reset sets every field to its default value. A wake from stop clears only the prescaler bit.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset the register read gives 0x00, `sys_clk_en` pulses once every 2 cycles, `stopped`, `wake_pulse` and `rst_req` are low.
- R2: A read at address 0x0B returns {flag, 7'b0}. A read at any other address returns 0. A write at any other address changes nothing.
- R3: Write data bit 7 has no effect. The flag cannot be set or cleared by a write.
- R4: Write bit 1 (fast) and bit 0 (prescale) set the enable period: fast=1/prescale=0 gives 1, 0/0 gives 2, 1/1 gives 16, 0/1 gives 32 input cycles.
- R5: `stop_enter` puts the block in stop at the next edge. While stopped, `sys_clk_en` stays low.
- R6: Write bits 4:2 choose the wake source: 000 none (stop is left only by reset), 001 to 100 p3 pins 0 to 3, 101 p2 pin 7, 110 NOR of p2[3:0], 111 NOR of p2[7:0]. Pins that are not selected have no effect.
- R7: Write bit 6 sets the wake level: 0 wakes on a low source, 1 on a high source.
- R8: A matching source level that is applied between edges gives a one-cycle `wake_pulse` after the third following rising edge. `stopped` falls at that same edge. This delay comes from two synchronising flops and one pulse register.
- R9: The flag is set on every wake from stop and stays set until the next reset.
- R10: A wake clears the prescale bit. The fast bit, the source, the level and the delay bit are kept.
- R11: `rst_req` rises together with `wake_pulse`. It stays high for 64 cycles when write bit 5 (delay, default 1) is 1, and for 1 cycle when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock, derived from the crystal |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the strobe |
| stop_enter | input | 1 | Request to enter the stop state |
| p3_pins | input | 4 | Port-3 wake candidates, pins 0 to 3 |
| p2_pins | input | 8 | Port-2 wake candidates, pins 0 to 7 |
| sys_clk_en | output | 1 | Clock enable for the system and timer logic |
| stopped | output | 1 | Block is in the stop state |
| wake_pulse | output | 1 | One-cycle recovery event |
| rst_req | output | 1 | Reset request issued after a wake |

## Verification
The hardest state to reach from the ports is a stopped device whose pins are already moving. Wakes must fire only on the selected source at the programmed level. At the same time the clearing of the prescaler and the keeping of the other fields must show up only indirectly, after the wake. Each wake scenario first settles the pins at a level that does not match, then programs the register and enters stop. It next moves only pins that are not selected and confirms that no wake happens. Only after that does it drive the matching level and count edges to the pulse.

The kept and cleared fields are then read back through behaviour. The enable period is measured after the wake, the length of the reset request is counted, and the flag is read on the bus.

// File: rtl/swk_pkg.sv
package swk_pkg;

    localparam int SWK_ADDR_W  = 8;
    localparam int SWK_DATA_W  = 8;
    localparam int SWK_CFG_W   = 7;

    typedef enum logic [2:0] {
        SRC_NONE      = 3'd0,
        SRC_P3_0      = 3'd1,
        SRC_P3_1      = 3'd2,
        SRC_P3_2      = 3'd3,
        SRC_P3_3      = 3'd4,
        SRC_P2_7      = 3'd5,
        SRC_P2_LO_NOR = 3'd6,
        SRC_P2_NOR    = 3'd7
    } wake_src_e;

    // field order follows the bus bit positions 6 down to 0
    typedef struct packed {
        logic      pol_high;
        logic      delay_en;
        wake_src_e src;
        logic      fast_clk;
        logic      presc_on;
    } swk_cfg_t;

    localparam swk_cfg_t CFG_DEFAULT = '{
        pol_high: 1'b0,
        delay_en: 1'b1,
        src:      SRC_NONE,
        fast_clk: 1'b0,
        presc_on: 1'b0
    };

    // last count value of the enable divider (period minus one)
    function automatic int div_last(input logic fast, input logic presc, input int pre);
        int base;
        base = fast ? 1 : 2;
        return (presc ? base * pre : base) - 1;
    endfunction

endpackage

// File: rtl/swk_cfg_reg.sv
module swk_cfg_reg
    import swk_pkg::*;
#(
    parameter int                 ADDR_W   = SWK_ADDR_W,
    parameter int                 DATA_W   = SWK_DATA_W,
    parameter logic [ADDR_W-1:0]  REG_ADDR = 8'h0B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              recover,
    output swk_cfg_t          cfg,
    output logic              stop_flag,
    output logic              wr_hit,
    output logic [DATA_W-1:0] rdata
);

    logic rd_hit;
    logic unused_wtop;

    assign wr_hit      = wr && (addr == REG_ADDR);
    assign rd_hit      = rd && (addr == REG_ADDR);
    assign unused_wtop = ^wdata[DATA_W-1:SWK_CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= CFG_DEFAULT;
            stop_flag <= 1'b0;
        end else begin
            if (wr_hit) begin
                cfg <= swk_cfg_t'(wdata[SWK_CFG_W-1:0]);
            end
            if (recover) begin
                cfg.presc_on <= 1'b0;
                stop_flag    <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            rdata[DATA_W-1] = stop_flag;
        end
    end

endmodule

// File: rtl/swk_wake_det.sv
module swk_wake_det
    import swk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int P3_W        = 4,
    parameter int P2_W        = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            armed,
    input  wake_src_e       src,
    input  logic            pol_high,
    input  logic [P3_W-1:0] p3,
    input  logic [P2_W-1:0] p2,
    output logic            match
);

    localparam int HALF = P2_W / 2;

    logic                   raw_sel;
    logic [SYNC_STAGES-1:0] sync_q;

    always_comb begin
        unique case (src)
            SRC_P3_0:      raw_sel = p3[0];
            SRC_P3_1:      raw_sel = p3[1];
            SRC_P3_2:      raw_sel = p3[2];
            SRC_P3_3:      raw_sel = p3[3];
            SRC_P2_7:      raw_sel = p2[P2_W-1];
            SRC_P2_LO_NOR: raw_sel = ~|p2[HALF-1:0];
            SRC_P2_NOR:    raw_sel = ~|p2;
            default:       raw_sel = 1'b0;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[g] <= 1'b0;
                end else if (g == 0) begin
                    sync_q[g] <= raw_sel;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign match = armed && (src != SRC_NONE) && (sync_q[SYNC_STAGES-1] == pol_high);

endmodule

// File: rtl/swk_clk_div.sv
module swk_clk_div
    import swk_pkg::*;
#(
    parameter int PRE_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic restart,
    input  logic fast_clk,
    input  logic presc_on,
    output logic en
);

    localparam int CNT_W = $clog2(2 * PRE_DIV);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last = CNT_W'(div_last(fast_clk, presc_on, PRE_DIV));

    always_ff @(posedge clk) begin
        if (rst || hold || restart) begin
            cnt_q <= '0;
        end else if (cnt_q >= last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign en = !hold && (cnt_q == '0);

endmodule

// File: rtl/swk_rst_delay.sv
module swk_rst_delay #(
    parameter int DELAY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic delay_en,
    output logic rst_req
);

    localparam int CW = $clog2(DELAY_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            rst_req <= 1'b1;
            cnt_q   <= delay_en ? CW'(DELAY_CYCLES - 1) : '0;
        end else if (rst_req) begin
            if (cnt_q == '0) begin
                rst_req <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swk_pkg::*;
#(
    parameter int                 ADDR_W       = SWK_ADDR_W,
    parameter int                 DATA_W       = SWK_DATA_W,
    parameter logic [ADDR_W-1:0]  REG_ADDR     = 8'h0B,
    parameter int                 PRE_DIV      = 16,
    parameter int                 DELAY_CYCLES = 64,
    parameter int                 SYNC_STAGES  = 2
) (
    input  logic              clk_in,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stop_enter,
    input  logic [3:0]        p3_pins,
    input  logic [7:0]        p2_pins,
    output logic              sys_clk_en,
    output logic              stopped,
    output logic              wake_pulse,
    output logic              rst_req
);

    swk_cfg_t cfg;
    logic     stop_flag;
    logic     wr_hit;
    logic     match;

    swk_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk(clk_in), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .recover(match), .cfg(cfg), .stop_flag(stop_flag),
        .wr_hit(wr_hit), .rdata(bus_rdata)
    );

    swk_wake_det #(.SYNC_STAGES(SYNC_STAGES), .P3_W(4), .P2_W(8)) u_det (
        .clk(clk_in), .rst(rst), .armed(stopped), .src(cfg.src),
        .pol_high(cfg.pol_high), .p3(p3_pins), .p2(p2_pins), .match(match)
    );

    swk_clk_div #(.PRE_DIV(PRE_DIV)) u_div (
        .clk(clk_in), .rst(rst), .hold(stopped), .restart(wr_hit),
        .fast_clk(cfg.fast_clk), .presc_on(cfg.presc_on), .en(sys_clk_en)
    );

    swk_rst_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_dly (
        .clk(clk_in), .rst(rst), .start(match), .delay_en(cfg.delay_en),
        .rst_req(rst_req)
    );

    always_ff @(posedge clk_in) begin
        if (rst) begin
            stopped    <= 1'b0;
            wake_pulse <= 1'b0;
        end else begin
            wake_pulse <= match;
            if (match) begin
                stopped <= 1'b0;
            end else if (stop_enter) begin
                stopped <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/swk_chk.sv
module swk_chk #(
    parameter int DELAY_CYCLES = 64,
    parameter int DATA_W       = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              stopped,
    input logic              sys_clk_en,
    input logic              wake_pulse,
    input logic              rst_req,
    input logic              stop_flag,
    input logic [DATA_W-1:0] rdata
);

    localparam int LW = $clog2(DELAY_CYCLES + 2) + 1;

    logic [LW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (rst_req) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R5
    en_quiet_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !sys_clk_en);

    // R8
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    // R8
    wake_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> ($past(stopped) && !stopped));

    // R9
    flag_on_wake_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> stop_flag);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stop_flag |=> stop_flag);

    // R11
    req_starts_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> wake_pulse);

    // R11
    req_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> (run_len == LW'(DELAY_CYCLES) || run_len == LW'(1)));

    // R2
    read_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-2:0] == '0);

endmodule

bind stop_wake_ctrl swk_chk #(.DELAY_CYCLES(DELAY_CYCLES), .DATA_W(DATA_W)) u_chk (
    .clk(clk_in), .rst(rst), .stopped(stopped), .sys_clk_en(sys_clk_en),
    .wake_pulse(wake_pulse), .rst_req(rst_req), .stop_flag(stop_flag),
    .rdata(bus_rdata)
);

// File: tb/stop_wake_ctrl_tb_top.sv
module stop_wake_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       stop_enter = 1'b0;
    logic [3:0] p3_pins = 4'hF;
    logic [7:0] p2_pins = 8'hFF;
    logic       sys_clk_en;
    logic       stopped;
    logic       wake_pulse;
    logic       rst_req;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    stop_wake_ctrl dut_i (
        .clk_in(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stop_enter(stop_enter), .p3_pins(p3_pins), .p2_pins(p2_pins),
        .sys_clk_en(sys_clk_en), .stopped(stopped), .wake_pulse(wake_pulse),
        .rst_req(rst_req)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        tick();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        tick();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        tick();
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic measure_period(output int per);
        int guard = 0;
        per = 0;
        while (!sys_clk_en && guard < 100) begin tick(); guard++; end
        tick(); per = 1;
        while (!sys_clk_en && per < 100) begin tick(); per++; end
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        int per;
        rd_reg(8'h0B, d);
        chk("R1", "reset read", int'(d), 0);
        chk("R1", "reset stopped", int'(stopped), 0);
        chk("R1", "reset wake_pulse", int'(wake_pulse), 0);
        chk("R1", "reset rst_req", int'(rst_req), 0);
        measure_period(per);
        chk("R1", "reset enable period", per, 2);
    endtask

    task automatic t_ratios();
        int per;
        wr_reg(8'h0B, 8'h22); measure_period(per); chk("R4", "fast period", per, 1);
        wr_reg(8'h0B, 8'h21); measure_period(per); chk("R4", "div2+presc period", per, 32);
        wr_reg(8'h0B, 8'h23); measure_period(per); chk("R4", "fast+presc period", per, 16);
        wr_reg(8'h0B, 8'h20); measure_period(per); chk("R4", "div2 period", per, 2);
        wr_reg(8'h0A, 8'h22); measure_period(per); chk("R2", "other address write ignored", per, 2);
    endtask

    task automatic t_read_map();
        logic [7:0] d;
        wr_reg(8'h0B, 8'hA0);
        rd_reg(8'h0B, d);
        chk("R3", "bit7 write does not set flag", int'(d), 0);
        rd_reg(8'h0C, d);
        chk("R2", "other address reads zero", int'(d), 0);
    endtask

    task automatic do_wake(input string tag, input logic [7:0] cfgv,
                           input logic [3:0] p3_idle, input logic [7:0] p2_idle,
                           input logic [3:0] p3_decoy, input logic [7:0] p2_decoy,
                           input logic [3:0] p3_hit, input logic [7:0] p2_hit,
                           input int exp_req_len, input int exp_period);
        int woke = 0;
        int quiet_en = 0;
        int len;
        int per;
        logic [7:0] d;
        tick();
        p3_pins = p3_idle; p2_pins = p2_idle;
        repeat (3) tick();
        wr_reg(8'h0B, cfgv);
        tick();
        stop_enter = 1'b1;
        tick();
        stop_enter = 1'b0;
        chk("R5", {tag, " stopped after stop_enter"}, int'(stopped), 1);
        p3_pins = p3_decoy; p2_pins = p2_decoy;
        repeat (8) begin
            tick();
            if (wake_pulse || !stopped) woke++;
            if (sys_clk_en) quiet_en++;
        end
        chk("R6", {tag, " unselected pins ignored"}, woke, 0);
        chk("R5", {tag, " enable low in stop"}, quiet_en, 0);
        p3_pins = p3_hit; p2_pins = p2_hit;
        tick(); tick();
        chk("R8", {tag, " no pulse before third edge"}, int'(wake_pulse), 0);
        tick();
        chk("R8", {tag, " pulse at third edge"}, int'(wake_pulse), 1);
        chk("R8", {tag, " stopped cleared"}, int'(stopped), 0);
        chk("R11", {tag, " rst_req with pulse"}, int'(rst_req), 1);
        len = 1;
        tick();
        chk("R8", {tag, " pulse one cycle"}, int'(wake_pulse), 0);
        while (rst_req && len < 200) begin len++; tick(); end
        chk("R11", {tag, " rst_req length"}, len, exp_req_len);
        rd_reg(8'h0B, d);
        chk("R9", {tag, " flag after wake"}, int'(d), 8'h80);
        measure_period(per);
        chk("R10", {tag, " period after wake"}, per, exp_period);
    endtask

    task automatic t_flag_write();
        logic [7:0] d;
        wr_reg(8'h0B, 8'h00);
        rd_reg(8'h0B, d);
        chk("R3", "write cannot clear flag", int'(d), 8'h80);
    endtask

    task automatic t_no_source();
        int woke = 0;
        int quiet_en = 0;
        logic [7:0] d;
        tick();
        p3_pins = 4'hF; p2_pins = 8'hFF;
        wr_reg(8'h0B, 8'h20);
        tick();
        stop_enter = 1'b1;
        tick();
        stop_enter = 1'b0;
        p3_pins = 4'h0; p2_pins = 8'h00;
        repeat (8) begin tick(); if (wake_pulse || !stopped) woke++; if (sys_clk_en) quiet_en++; end
        p3_pins = 4'hF; p2_pins = 8'hFF;
        repeat (8) begin tick(); if (wake_pulse || !stopped) woke++; if (sys_clk_en) quiet_en++; end
        chk("R6", "source none never wakes", woke, 0);
        chk("R5", "enable low in long stop", quiet_en, 0);
        do_reset();
        chk("R6", "reset leaves stop", int'(stopped), 0);
        rd_reg(8'h0B, d);
        chk("R9", "reset clears flag", int'(d), 0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_ratios();
        t_read_map();
        // R7 R10: p3[0] low, delay on, fast+presc kept fast only
        do_wake("p3_0 low", 8'h27, 4'hF, 8'hFF, 4'b1101, 8'hFF, 4'b1110, 8'hFF, 64, 1);
        t_flag_write();
        // R7: p3[1] high, no delay
        do_wake("p3_1 high", 8'h48, 4'h0, 8'h00, 4'b1101, 8'h00, 4'b0010, 8'h00, 1, 2);
        do_wake("p3_2 low", 8'h2C, 4'hF, 8'hFF, 4'b0100, 8'hFF, 4'b0000, 8'hFF, 64, 2);
        do_wake("p3_3 high", 8'h50, 4'h0, 8'h00, 4'b0111, 8'h00, 4'b1000, 8'h00, 1, 2);
        do_wake("p2_7 low", 8'h35, 4'hF, 8'hFF, 4'hF, 8'h80, 4'hF, 8'h00, 64, 2);
        do_wake("p2 low nor high", 8'h7A, 4'h0, 8'h01, 4'h0, 8'hF1, 4'h0, 8'hF0, 64, 1);
        do_wake("p2 nor high", 8'h5C, 4'h0, 8'h80, 4'h0, 8'h10, 4'h0, 8'h00, 1, 2);
        do_wake("p2 low nor low", 8'h18, 4'h0, 8'hF0, 4'h0, 8'h00, 4'h0, 8'h08, 1, 2);
        t_no_source();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule